// File: doc/BRIEF.md
# Flash Completion Status Poller

This block sits on the host side of a parallel flash device and decides whether an embedded program or erase operation has finished successfully. After a start pulse it repeatedly issues read requests to one target address and inspects each returned status byte. The verdict is reached in one of two ways. The completion-bit method compares bit 7 with the expected data. The toggle method watches bit 6 across successive reads. Either way, bit 5 marks that the device has exceeded its internal time limit.

Because the completion indication can change in the same read in which the time-limit flag first appears, the poller always performs a confirming read (or a confirming pair of reads in toggle mode) after bit 5 is seen, and only then declares failure. A host-side watchdog with a parameterised cycle limit ends a poll that never concludes. For an erase, the caller supplies expected data with bit 7 set and chooses an address inside a sector being erased. Issuing the command sequence and any retry policy belong to the caller.

Top module: `flash_poll_engine`

## Requirements
- R1: After reset, rd_req_o, done_o, pass_o and fail_o are all low.
- R2: A start pulse seen while idle latches the mode, the expected byte and the address, clears pass_o and fail_o, and raises rd_req_o with rd_addr_o equal to the latched address in the next cycle.
- R3: rd_req_o stays high until a cycle with rd_ack_i high. The byte on rd_data_i is taken in that cycle, and rd_addr_o does not change while a request is pending.
- R4: In completion-bit mode (toggle_mode_i = 0), a read whose bit 7 (mask 0x80) equals bit 7 of the expected byte gives a pass. This holds even if bit 5 is set in the same byte.
- R5: In completion-bit mode, a read with bit 7 mismatched and bit 5 (mask 0x20) clear starts another read.
- R6: In completion-bit mode, a read with bit 7 mismatched and bit 5 set causes exactly one more read. That read gives a pass if its bit 7 matches, and a fail otherwise.
- R7: In toggle mode (toggle_mode_i = 1), the first read is only a baseline. Each later read compares its bit 6 (mask 0x40) with that of the read before it. Equal values give a pass. A difference with bit 5 clear starts another read.
- R8: In toggle mode, a bit-6 difference with bit 5 set causes exactly two more reads. The poll passes if their bit 6 values are equal, and fails otherwise.
- R9: If no verdict is reached within WD_LIMIT cycles of rd_req_o being high, the poll ends as a fail. A read that concludes in the final cycle decides the result instead.
- R10: done_o is high for exactly one cycle, the cycle after the deciding read or the expiry. Exactly one of pass_o and fail_o is high from then on, and both hold until the next accepted start.
- R11: A start pulse while a poll is running is ignored. It does not change the mode, the expected byte or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a poll (accepted only when idle) |
| toggle_mode_i | input | 1 | 0 selects completion-bit method, 1 selects toggle method |
| poll_addr_i | input | ADDR_W | Address to poll |
| expect_i | input | 8 | Expected data byte (bit 7 used by completion-bit method) |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Address of the read |
| rd_ack_i | input | 1 | Read response valid |
| rd_data_i | input | 8 | Status byte returned with rd_ack_i |
| done_o | output | 1 | One-cycle verdict strobe |
| pass_o | output | 1 | Operation completed successfully |
| fail_o | output | 1 | Operation failed or watchdog expired |

## Verification
Two functions can meet in one cycle: a read response that settles the poll, and the watchdog reaching its limit. The bench delays the responder so that the acknowledge lands exactly in the last allowed cycle. It judges that a conclusive byte yields a pass, that an inconclusive byte yields a fail, and that a response one cycle later is never taken. A second coincidence lives inside the status byte, where bit 5 and a matching completion bit arrive together. The bench checks that this case passes at once without a confirming read.

// File: rtl/fpe_pkg.sv
package fpe_pkg;

  localparam int STATUS_W  = 8;
  localparam int BIT_DONE  = 7;
  localparam int BIT_TOG   = 6;
  localparam int BIT_LIMIT = 5;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_READ = 1'b1
  } fpe_state_t;

  typedef enum logic [1:0] {
    PH_FIRST  = 2'd0,
    PH_POLL   = 2'd1,
    PH_CONF_A = 2'd2,
    PH_CONF_B = 2'd3
  } fpe_phase_t;

  function automatic logic done_bit_agrees(input logic [STATUS_W-1:0] rd,
                                           input logic [STATUS_W-1:0] want);
    return rd[BIT_DONE] == want[BIT_DONE];
  endfunction

  function automatic logic tog_bit_moved(input logic [STATUS_W-1:0] now_b,
                                         input logic [STATUS_W-1:0] before_b);
    return now_b[BIT_TOG] != before_b[BIT_TOG];
  endfunction

  function automatic logic limit_seen(input logic [STATUS_W-1:0] rd);
    return rd[BIT_LIMIT];
  endfunction

endpackage

// File: rtl/fpe_verdict.sv
module fpe_verdict
  import fpe_pkg::*;
(
  input  logic                toggle_mode,
  input  fpe_phase_t          phase,
  input  logic [STATUS_W-1:0] rd_byte,
  input  logic [STATUS_W-1:0] want_byte,
  input  logic [STATUS_W-1:0] prev_byte,
  output logic                conclude,
  output logic                good,
  output fpe_phase_t          nxt_phase,
  output logic                keep_byte
);

  logic agree;
  logic moved;
  logic limit;

  assign agree = done_bit_agrees(rd_byte, want_byte);
  assign moved = tog_bit_moved(rd_byte, prev_byte);
  assign limit = limit_seen(rd_byte);

  always_comb begin
    conclude  = 1'b0;
    good      = 1'b0;
    nxt_phase = phase;
    keep_byte = 1'b0;
    if (!toggle_mode) begin
      if (phase == PH_CONF_A) begin
        conclude = 1'b1;
        good     = agree;
      end else if (agree) begin
        conclude = 1'b1;
        good     = 1'b1;
      end else if (limit) begin
        nxt_phase = PH_CONF_A;
      end else begin
        nxt_phase = PH_POLL;
      end
    end else begin
      case (phase)
        PH_FIRST: begin
          keep_byte = 1'b1;
          nxt_phase = PH_POLL;
        end
        PH_POLL: begin
          if (!moved) begin
            conclude = 1'b1;
            good     = 1'b1;
          end else if (limit) begin
            nxt_phase = PH_CONF_A;
          end else begin
            keep_byte = 1'b1;
          end
        end
        PH_CONF_A: begin
          keep_byte = 1'b1;
          nxt_phase = PH_CONF_B;
        end
        default: begin
          conclude = 1'b1;
          good     = !moved;
        end
      endcase
    end
  end

endmodule

// File: rtl/fpe_watchdog.sv
module fpe_watchdog #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expire
);

  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (run && cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire = run && (cnt_q == LAST);

  // R9: the count never passes the limit while a poll runs
  a_r9_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < CNT_W'(LIMIT)));

  // R9: a fresh poll starts its window from zero
  a_r9_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine
  import fpe_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int WD_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              toggle_mode_i,
  input  logic [ADDR_W-1:0] poll_addr_i,
  input  logic [7:0]        expect_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [7:0]        rd_data_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o
);

  fpe_state_t          state_q;
  fpe_phase_t          phase_q;
  logic                mode_q;
  logic [STATUS_W-1:0] exp_q;
  logic [STATUS_W-1:0] prev_q;
  logic [ADDR_W-1:0]   addr_q;
  logic                done_q;
  logic                pass_q;
  logic                fail_q;

  logic       busy;
  logic       start_take;
  logic       rd_take;
  logic       dec_conclude;
  logic       dec_good;
  logic       dec_keep;
  fpe_phase_t dec_phase;
  logic       wd_expire;
  logic       conclude_rd;
  logic       wd_fail;
  logic       finish;
  logic       verdict_good;

  assign busy       = (state_q == ST_READ);
  assign start_take = (state_q == ST_IDLE) && start_i;
  assign rd_take    = busy && rd_ack_i;

  fpe_verdict u_verdict (
    .toggle_mode (mode_q),
    .phase       (phase_q),
    .rd_byte     (rd_data_i),
    .want_byte   (exp_q),
    .prev_byte   (prev_q),
    .conclude    (dec_conclude),
    .good        (dec_good),
    .nxt_phase   (dec_phase),
    .keep_byte   (dec_keep)
  );

  fpe_watchdog #(.LIMIT(WD_LIMIT)) u_watchdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (start_take),
    .run    (busy),
    .expire (wd_expire)
  );

  assign conclude_rd  = rd_take && dec_conclude;
  assign wd_fail      = wd_expire && !conclude_rd;
  assign finish       = conclude_rd || wd_fail;
  assign verdict_good = conclude_rd && dec_good;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_FIRST;
      mode_q  <= 1'b0;
      exp_q   <= '0;
      prev_q  <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      done_q <= finish;
      if (start_take) begin
        state_q <= ST_READ;
        phase_q <= PH_FIRST;
        mode_q  <= toggle_mode_i;
        exp_q   <= expect_i;
        addr_q  <= poll_addr_i;
        pass_q  <= 1'b0;
        fail_q  <= 1'b0;
      end else if (finish) begin
        state_q <= ST_IDLE;
        pass_q  <= verdict_good;
        fail_q  <= !verdict_good;
      end else if (rd_take) begin
        phase_q <= dec_phase;
        if (dec_keep) prev_q <= rd_data_i;
      end
    end
  end

  assign rd_req_o  = busy;
  assign rd_addr_o = addr_q;
  assign done_o    = done_q;
  assign pass_o    = pass_q;
  assign fail_o    = fail_q;

  // R10: the verdict strobe lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: a strobe always carries exactly one result
  a_r10_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pass_o ^ fail_o));

  // R10: result held while idle and no start arrives
  a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_i) |=> ($stable(pass_o) && $stable(fail_o)));

  // R3: no request is outstanding during the verdict strobe
  a_r3_req_quiet_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rd_req_o);

  // R3: address held while a request waits
  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ack_i) |=> $stable(rd_addr_o));

  // R11: a running poll keeps its settings until it ends
  a_r11_settings_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> (busy && $stable(exp_q) && $stable(mode_q)));

  // R6: a confirming read in completion-bit mode always ends the poll
  a_r6_confirm_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q && phase_q == PH_CONF_A && rd_ack_i) |=> done_o);

endmodule

// File: tb/tb_flash_poll_engine.sv
module tb_flash_poll_engine;

  localparam int AW = 20;
  localparam int WD = 40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i;
  logic          toggle_mode_i;
  logic [AW-1:0] poll_addr_i;
  logic [7:0]    expect_i;
  logic          rd_req_o;
  logic [AW-1:0] rd_addr_o;
  logic          rd_ack_i;
  logic [7:0]    rd_data_i;
  logic          done_o;
  logic          pass_o;
  logic          fail_o;

  always #4 clk = ~clk;

  flash_poll_engine #(.ADDR_W(AW), .WD_LIMIT(WD)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .toggle_mode_i(toggle_mode_i),
    .poll_addr_i(poll_addr_i), .expect_i(expect_i), .rd_req_o(rd_req_o),
    .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
    .done_o(done_o), .pass_o(pass_o), .fail_o(fail_o)
  );

  int n_checks = 0;
  int n_errs   = 0;
  int cyc      = 0;
  bit run_cmp  = 0;

  byte unsigned rsp_q[$];
  int lat        = 0;
  int wait_cnt   = 0;
  int reads_seen = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // responder: acknowledges after lat waiting cycles while a byte is queued
  always @(negedge clk) begin
    if (rst_n && rd_req_o && rsp_q.size() > 0) begin
      if (wait_cnt >= lat) begin
        rd_ack_i  = 1'b1;
        rd_data_i = rsp_q.pop_front();
        reads_seen++;
        wait_cnt  = 0;
      end else begin
        rd_ack_i = 1'b0;
        wait_cnt++;
      end
    end else begin
      rd_ack_i = 1'b0;
      wait_cnt = 0;
    end
  end

  // behavioural reference model
  int m_busy, m_done, m_pass, m_fail, m_ph, m_cnt, m_mode, mv;
  logic [7:0] m_exp, m_prev, md;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_done <= 0; m_pass <= 0; m_fail <= 0;
      m_ph <= 0; m_cnt <= 0; m_mode <= 0; m_exp <= 0; m_prev <= 0;
    end else begin
      m_done <= 0;
      if (m_busy == 0) begin
        if (start_i) begin
          m_busy <= 1; m_mode <= int'(toggle_mode_i); m_exp <= expect_i;
          m_pass <= 0; m_fail <= 0; m_ph <= 0; m_cnt <= 0;
        end
      end else begin
        mv = 0;
        if (rd_ack_i) begin
          md = rd_data_i;
          if (m_mode == 0) begin
            if (m_ph == 2) mv = (md[7] == m_exp[7]) ? 1 : 2;
            else if (md[7] == m_exp[7]) mv = 1;
            else if (md[5]) m_ph <= 2;
          end else begin
            if (m_ph == 0) begin m_prev <= md; m_ph <= 1; end
            else if (m_ph == 1) begin
              if (md[6] == m_prev[6]) mv = 1;
              else if (md[5]) m_ph <= 2;
              else m_prev <= md;
            end else if (m_ph == 2) begin m_prev <= md; m_ph <= 3; end
            else mv = (md[6] == m_prev[6]) ? 1 : 2;
          end
        end
        if (mv == 0 && m_cnt == WD - 1) mv = 2;
        m_cnt <= m_cnt + 1;
        if (mv != 0) begin
          m_busy <= 0; m_done <= 1;
          m_pass <= (mv == 1) ? 1 : 0;
          m_fail <= (mv == 2) ? 1 : 0;
        end
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && run_cmp) begin
      check(int'(rd_req_o) == m_busy, "R3",  "rd_req_o vs model", int'(rd_req_o), m_busy);
      check(int'(done_o)   == m_done, "R10", "done_o vs model",   int'(done_o),   m_done);
      check(int'(pass_o)   == m_pass, "R10", "pass_o vs model",   int'(pass_o),   m_pass);
      check(int'(fail_o)   == m_fail, "R10", "fail_o vs model",   int'(fail_o),   m_fail);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  int addr_seed = 20'h1_2340;

  task automatic run(input bit tog, input logic [7:0] ex, input int latv,
                     input int exp_reads, input bit exp_pass, input int exp_k,
                     input bit poke, input string tag);
    int k;
    logic [AW-1:0] a;
    @(negedge clk);
    a = AW'(addr_seed);
    addr_seed = addr_seed + 20'h0_1011;
    lat = latv; reads_seen = 0;
    toggle_mode_i = tog; expect_i = ex; poll_addr_i = a; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(rd_req_o == 1'b1, "R2", "request after start", int'(rd_req_o), 1);
    check(rd_addr_o == a, "R2", "address latched", int'(rd_addr_o), int'(a));
    check(!pass_o && !fail_o, "R2", "result cleared", int'({pass_o, fail_o}), 0);
    k = 0;
    while (!done_o && k < 2000) begin
      if (poke && k == 2) begin
        start_i = 1'b1; expect_i = ~ex; toggle_mode_i = ~tog;
      end else if (poke && k == 3) begin
        start_i = 1'b0; expect_i = ex; toggle_mode_i = tog;
      end
      @(negedge clk);
      k++;
    end
    start_i = 1'b0;
    check(done_o == 1'b1, tag, "done seen", int'(done_o), 1);
    check(pass_o == exp_pass, tag, "pass verdict", int'(pass_o), int'(exp_pass));
    check(fail_o == !exp_pass, tag, "fail verdict", int'(fail_o), int'(!exp_pass));
    check(reads_seen == exp_reads, tag, "reads used", reads_seen, exp_reads);
    if (exp_k >= 0) check(k == exp_k, tag, "cycles to verdict", k, exp_k);
    @(negedge clk);
    check(!done_o && pass_o == exp_pass && fail_o == !exp_pass, "R10",
          "strobe ends, result held", int'({done_o, pass_o, fail_o}),
          int'({1'b0, exp_pass, !exp_pass}));
    rsp_q.delete();
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; toggle_mode_i = 1'b0;
    poll_addr_i = '0; expect_i = '0; rd_ack_i = 1'b0; rd_data_i = '0;
    repeat (3) @(negedge clk);
    check(!rd_req_o && !done_o && !pass_o && !fail_o, "R1", "outputs at reset",
          int'({rd_req_o, done_o, pass_o, fail_o}), 0);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    @(negedge clk);
    check(!rd_req_o && !done_o && !pass_o && !fail_o, "R1", "idle after reset",
          int'({rd_req_o, done_o, pass_o, fail_o}), 0);

    // R4: immediate match (erase style, bit7 = 1)
    rsp_q = '{8'h80};                 run(0, 8'h80, 0, 1, 1, -1, 0, "R4");
    // R4: match with bit5 also set -> pass, no confirm read
    rsp_q = '{8'hA0};                 run(0, 8'h80, 2, 1, 1, -1, 0, "R4");
    // R5: two mismatches without bit5, then a match
    rsp_q = '{8'h80, 8'h80, 8'h00};   run(0, 8'h5A, 1, 3, 1, -1, 0, "R5");
    // R6: bit5 then confirming read matches
    rsp_q = '{8'hA0, 8'h00};          run(0, 8'h00, 0, 2, 1, -1, 0, "R6");
    // R6: bit5 then confirming read still mismatched
    rsp_q = '{8'hA0, 8'hA0, 8'h00};   run(0, 8'h00, 0, 2, 0, -1, 0, "R6");
    // R7: bit6 steady at once
    rsp_q = '{8'h40, 8'h40};          run(1, 8'h00, 0, 2, 1, -1, 0, "R7");
    // R7: toggling then steady
    rsp_q = '{8'h00, 8'h40, 8'h00, 8'h00}; run(1, 8'h00, 1, 4, 1, -1, 0, "R7");
    // R8: bit5 during toggle, confirming pair still toggles
    rsp_q = '{8'h00, 8'h60, 8'h00, 8'h40}; run(1, 8'h00, 0, 4, 0, -1, 0, "R8");
    // R8: bit5 during toggle, confirming pair steady
    rsp_q = '{8'h00, 8'h60, 8'h40, 8'h40}; run(1, 8'h00, 0, 4, 1, -1, 0, "R8");
    // R9: no response at all
    rsp_q.delete();                   run(0, 8'h80, 0, 0, 0, WD, 0, "R9");
    // R9: conclusive response in the last allowed cycle wins
    rsp_q = '{8'h80};                 run(0, 8'h80, WD - 1, 1, 1, WD, 0, "R9");
    // R9: inconclusive response in the last cycle -> fail
    rsp_q = '{8'h00};                 run(0, 8'h80, WD - 1, 1, 0, WD, 0, "R9");
    // R9: response one cycle too late is never taken
    rsp_q = '{8'h80};                 run(0, 8'h80, WD, 0, 0, WD, 0, "R9");
    // R11: start pulse with other settings during a poll is ignored
    rsp_q = '{8'h00, 8'h00, 8'h80};   run(0, 8'h80, 3, 3, 1, -1, 1, "R11");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

endmodule